// File: doc/BRIEF.md
# Three-Shot Reclosing Sequencer

This block decides when a tripped breaker gets a reclose attempt. It starts in a reset state. A trip, or reclose-initiate, signal that arrives while the breaker is still closed moves it into a cycle state. After each trip it waits for the breaker to open and the fault current to clear. It then times a dead interval and issues a close command. Each shot has its own dead interval, and there are at most three shots.

After a close, a reset (reclaim) timer runs while the breaker stays closed. If the timer runs out, the block returns to reset and clears the shot count. If a trip arrives during the reclaim time, the next shot starts. A trip after the third shot ends in lockout.

Lockout is forced at any time by any of these:
- the enable switch being off,
- the high-set instantaneous flag,
- a manual-open request.

Lockout is also entered when the breaker opens in reset with no initiate. The same reclaim timer brings the block back from lockout. Every decision is taken on a cycle-rate tick strobe.

Top module: `recloser_seq`

## Requirements
- R1: After reset, `state_o` is 2'b00 (reset), `shot_o` is 0 and `close_o` is 0.
- R2: In the reset state, a tick with `initiate_i` high and `brk_closed_i` high moves `state_o` to 2'b01 (cycle) with `shot_o` 0.
- R3: In the reset state, a tick with `brk_closed_i` low, without a qualifying initiate, moves `state_o` to 2'b10 (lockout).
- R4: The dead-interval count advances only on ticks where the breaker is open and both `current_i` and `initiate_i` are low. On any other tick it restarts from zero.
- R5: The dead intervals are `OPEN1_TICKS`, `OPEN2_TICKS` and `OPEN3_TICKS` (30, 120 and 300) for shots one to three. On the tick where the interval expires, `close_o` rises and is held for exactly one tick period, and `shot_o` increments.
- R6: An initiate during the reclaim time starts the next shot's dead interval. An initiate after the third shot (`shot_o` = 3) moves the block to lockout.
- R7: On any tick with `enable_i` low, `hiset_i` high or `manual_open_i` high, the block enters lockout, `close_o` drops, and the reclaim count clears. This applies in every state.
- R8: The reclaim count advances on ticks with the breaker closed and clears on ticks with it open. After `RESET_TICKS` (300) consecutive counts, the block returns to reset from either the cycle or the lockout state, and `shot_o` becomes 0.
- R9: The outputs change only on clock edges where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Cycle-rate timebase strobe |
| initiate_i | input | 1 | Trip / reclose-initiate |
| brk_closed_i | input | 1 | Breaker status, 1 = closed |
| current_i | input | 1 | Fault current present |
| enable_i | input | 1 | Reclosing enable switch |
| hiset_i | input | 1 | High-set instantaneous element flag |
| manual_open_i | input | 1 | Manual open request |
| close_o | output | 1 | Close command, one tick period long |
| state_o | output | 2 | 00 reset, 01 cycle, 10 lockout |
| shot_o | output | 2 | Reclose attempts made in this sequence |

## Verification
The assertions check on every cycle the following:
- outputs stay frozen between ticks,
- forced lockout takes effect on the next edge,
- both exits from reset go where they should,
- a close pulse lasts one tick,
- the shot count is zero whenever the block is in reset.

Some behaviour only the bench scenarios can show:
- the exact length of each dead interval and of the reclaim time,
- the dead-interval restart when current returns,
- the reclaim restart when the breaker opens,
- the full three-shot walk into lockout and back to reset.

// File: rtl/recloser_seq.sv
module recloser_seq #(
  parameter int OPEN1_TICKS = 30,
  parameter int OPEN2_TICKS = 120,
  parameter int OPEN3_TICKS = 300,
  parameter int RESET_TICKS = 300
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       initiate_i,
  input  logic       brk_closed_i,
  input  logic       current_i,
  input  logic       enable_i,
  input  logic       hiset_i,
  input  logic       manual_open_i,
  output logic       close_o,
  output logic [1:0] state_o,
  output logic [1:0] shot_o
);
  localparam int MAXO = (OPEN1_TICKS > OPEN2_TICKS) ?
                        ((OPEN1_TICKS > OPEN3_TICKS) ? OPEN1_TICKS : OPEN3_TICKS) :
                        ((OPEN2_TICKS > OPEN3_TICKS) ? OPEN2_TICKS : OPEN3_TICKS);
  localparam int MAXT = (MAXO > RESET_TICKS) ? MAXO : RESET_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] L1 = TW'(OPEN1_TICKS - 1);
  localparam logic [TW-1:0] L2 = TW'(OPEN2_TICKS - 1);
  localparam logic [TW-1:0] L3 = TW'(OPEN3_TICKS - 1);
  localparam logic [TW-1:0] LR = TW'(RESET_TICKS - 1);

  typedef enum logic [1:0] {ST_RESET = 2'b00, ST_CYCLE = 2'b01, ST_LOCK = 2'b10} st_t;

  st_t           st;
  logic          reclaim;
  logic [TW-1:0] tmr;
  logic [TW-1:0] open_last;
  logic          force_lock, dead_ok;

  assign force_lock = !enable_i || hiset_i || manual_open_i;
  assign dead_ok    = !brk_closed_i && !current_i && !initiate_i;
  assign open_last  = (shot_o == 2'd0) ? L1 : (shot_o == 2'd1) ? L2 : L3;
  assign state_o    = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_RESET;
      reclaim <= 1'b0;
      tmr     <= '0;
      shot_o  <= 2'd0;
      close_o <= 1'b0;
    end else if (tick_i) begin
      close_o <= 1'b0;
      if (force_lock) begin
        st      <= ST_LOCK;
        reclaim <= 1'b0;
        tmr     <= '0;
      end else begin
        case (st)
          ST_RESET: begin
            tmr <= '0;
            if (initiate_i && brk_closed_i) begin
              st      <= ST_CYCLE;
              reclaim <= 1'b0;
              shot_o  <= 2'd0;
            end else if (!brk_closed_i) begin
              st <= ST_LOCK;
            end
          end
          ST_CYCLE: begin
            if (!reclaim) begin
              if (dead_ok) begin
                if (tmr == open_last) begin
                  close_o <= 1'b1;
                  shot_o  <= shot_o + 2'd1;
                  reclaim <= 1'b1;
                  tmr     <= '0;
                end else begin
                  tmr <= tmr + 1'b1;
                end
              end else begin
                tmr <= '0;
              end
            end else if (initiate_i) begin
              tmr <= '0;
              if (shot_o == 2'd3) st <= ST_LOCK;
              else reclaim <= 1'b0;
            end else if (brk_closed_i) begin
              if (tmr == LR) begin
                st      <= ST_RESET;
                reclaim <= 1'b0;
                shot_o  <= 2'd0;
                tmr     <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end else begin
              tmr <= '0;
            end
          end
          default: begin
            if (brk_closed_i) begin
              if (tmr == LR) begin
                st      <= ST_RESET;
                reclaim <= 1'b0;
                shot_o  <= 2'd0;
                tmr     <= '0;
              end else begin
                tmr <= tmr + 1'b1;
              end
            end else begin
              tmr <= '0;
            end
          end
        endcase
      end
    end
  end

  a_r9_frozen_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(state_o) && $stable(shot_o) && $stable(close_o));

  a_r7_forced_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && force_lock |=> state_o == 2'b10 && !close_o);

  a_r2_enter_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !force_lock && state_o == 2'b00 && initiate_i && brk_closed_i
    |=> state_o == 2'b01 && shot_o == 2'd0);

  a_r3_open_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !force_lock && state_o == 2'b00 && !brk_closed_i |=> state_o == 2'b10);

  a_r5_single_close: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && close_o |=> !close_o);

  a_r5_close_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(close_o) |-> state_o == 2'b01 && shot_o != 2'd0);

  a_r8_reset_has_no_shots: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == 2'b00 |-> shot_o == 2'd0);
endmodule

// File: tb/recloser_seq_tb.sv
module recloser_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic init = 1'b0, brk = 1'b1, cur = 1'b0, en = 1'b1, hs = 1'b0, mo = 1'b0;
  logic close_w;
  logic [1:0] state_w, shot_w;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  recloser_seq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .initiate_i(init),
    .brk_closed_i(brk), .current_i(cur), .enable_i(en), .hiset_i(hs),
    .manual_open_i(mo), .close_o(close_w), .state_o(state_w), .shot_o(shot_w)
  );

  int m_state = 0, m_shot = 0, m_close = 0, m_rec = 0, m_cnt = 0;
  int dead_len[3] = '{30, 120, 300};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_shot = 0; m_close = 0; m_rec = 0; m_cnt = 0;
    end else if (tick) begin
      m_close = 0;
      if (!en || hs || mo) begin
        m_state = 2; m_rec = 0; m_cnt = 0;
      end else if (m_state == 0) begin
        m_cnt = 0;
        if (init && brk) begin m_state = 1; m_rec = 0; m_shot = 0; end
        else if (!brk) m_state = 2;
      end else if (m_state == 1 && m_rec == 0) begin
        if (!brk && !cur && !init) begin
          m_cnt++;
          if (m_cnt == dead_len[m_shot]) begin
            m_close = 1; m_shot++; m_rec = 1; m_cnt = 0;
          end
        end else m_cnt = 0;
      end else if (m_state == 1 && init) begin
        m_cnt = 0;
        if (m_shot == 3) m_state = 2; else m_rec = 0;
      end else begin
        if (brk) begin
          m_cnt++;
          if (m_cnt == 300) begin m_state = 0; m_shot = 0; m_rec = 0; m_cnt = 0; end
        end else m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (state_w != m_state[1:0] || shot_w != m_shot[1:0] || close_w != m_close[0]) begin
        failures++;
        $display("FAIL %s/R9 t=%0t state=%0d shot=%0d close=%0d expected state=%0d shot=%0d close=%0d",
                 cur_req, $time, state_w, shot_w, close_w, m_state, m_shot, m_close);
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (2 * n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(3);
    chk("R1 state", state_w, 0); chk("R1 shot", shot_w, 0); chk("R1 close", close_w, 0);

    cur_req = "R2"; init = 1; step(1);
    chk("R2 state", state_w, 1); chk("R2 shot", shot_w, 0);

    cur_req = "R4"; brk = 0; cur = 1; step(5);
    init = 0; step(5);
    cur = 0; step(29);
    chk("R4 no close yet", close_w, 0); chk("R4 still cycle", state_w, 1);
    cur_req = "R5"; step(1);
    chk("R5 close shot1", close_w, 1); chk("R5 shot1", shot_w, 1);
    step(1);
    chk("R5 close one tick", close_w, 0);

    cur_req = "R6"; brk = 1; step(40);
    init = 1; brk = 0; step(1);
    init = 0; step(60);
    cur_req = "R4"; cur = 1; step(1); cur = 0; step(119);
    chk("R4 restart after current", close_w, 0);
    cur_req = "R5"; step(1);
    chk("R5 close shot2", close_w, 1); chk("R5 shot2", shot_w, 2);
    brk = 1; step(10);
    init = 1; brk = 0; step(1);
    init = 0; step(299);
    chk("R5 shot3 not early", close_w, 0);
    step(1);
    chk("R5 close shot3", close_w, 1); chk("R5 shot3", shot_w, 3);
    cur_req = "R6"; brk = 1; step(20);
    init = 1; step(1); init = 0;
    chk("R6 trip after third", state_w, 2); chk("R6 shot held", shot_w, 3);

    cur_req = "R8"; step(150); brk = 0; step(1); brk = 1; step(299);
    chk("R8 lockout held", state_w, 2);
    step(1);
    chk("R8 back to reset", state_w, 0); chk("R8 shot cleared", shot_w, 0);

    init = 1; step(1); init = 0; brk = 0; step(30);
    chk("R5 close first", close_w, 1);
    brk = 1; step(299);
    chk("R8 cycle held", state_w, 1);
    step(1);
    chk("R8 cycle to reset", state_w, 0); chk("R8 shot zero", shot_w, 0);

    for (int k = 0; k < 3; k++) begin
      cur_req = "R7";
      init = 1; step(1); init = 0; brk = 0; step(3);
      if (k == 0) en = 0; else if (k == 1) hs = 1; else mo = 1;
      step(1);
      chk("R7 forced lockout", state_w, 2); chk("R7 close low", close_w, 0);
      en = 1; hs = 0; mo = 0; brk = 1; step(300);
      chk("R8 reset after force", state_w, 0);
    end

    cur_req = "R3"; brk = 0; step(1);
    chk("R3 open in reset", state_w, 2);
    brk = 1; step(300);
    chk("R8 final reset", state_w, 0);

    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule